// File: doc/BRIEF.md
# Dual-rail to synchronous interface controller

This block takes one bit carried on a four-phase, dual-rail, delay-insensitive link (a "true" rail and a "false" rail) and turns it into a single-rail data bit plus a validity flag for a clocked consumer. It also produces the active-low acknowledge that closes the sender's handshake. A single state machine is responsible for both validity generation and completion detection. The validity flag records that a codeword has arrived and also that the rails have since returned to neutral. The acknowledge is simply the inverse of that flag, so the data-valid condition is evaluated only once.

The consumer registers the validity flag and returns that copy as a feedback bit. The block raises a request toward a stoppable clock source while it holds a fresh word. It waits for the matching grant together with the feedback bit before it lets the word retire. The rails are asynchronous, so they pass through a parameterised synchronizer before decoding. The feedback and grant inputs belong to the block's own clock domain.

The states are IDLE (flag low, waiting for a codeword), LOAD (word captured, request raised) and HOLD (consumer has seen the word, waiting for neutral rails). The transitions are: IDLE to LOAD on a legal codeword while feedback is low; LOAD to HOLD on grant with feedback high; HOLD to IDLE on empty rails.

Top module: `dr2s_ctrl`

## Requirements
- R1: After reset the data bit is 0, the validity flag is 0, the acknowledge is 1, the request is 0 and the error flag is 0.
- R2: True rail 1 with false rail 0 sets the validity flag and the data bit to 1 on the third rising clock edge after the rails change (SYNC_STAGES=2 synchronizer stages plus the state register).
- R3: False rail 1 with true rail 0 sets the validity flag to 1 and the data bit to 0 with the same latency as R2.
- R4: When both rails are 0 and the previous word has retired, the validity flag is 0 and the data bit keeps the value of the last word.
- R5: The acknowledge output is at every clock edge the inverse of the validity flag.
- R6: The request is 1 from the edge where the validity flag rises until the edge on which grant and feedback are both 1; it then returns to 0 while the flag stays 1.
- R7: The validity flag falls only after the word has reached HOLD and the synchronized rails are empty. If the rails are empty but grant has not come, the flag stays 1.
- R8: A new codeword is accepted from IDLE only while the feedback bit is 0. While feedback stays 1, the flag stays 0.
- R9: Both rails at 1 is illegal. It changes neither the validity flag nor the data bit, and it sets a sticky error flag that only reset clears.
- R10: The data bit does not change while the validity flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of the synchronous side |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_t | input | 1 | True rail of the dual-rail input |
| rail_f | input | 1 | False rail of the dual-rail input |
| sv_fb | input | 1 | Consumer's registered copy of the validity flag |
| grant | input | 1 | Grant from the stoppable clock source |
| sync_data | output | 1 | Single-rail data bit |
| sync_valid | output | 1 | Validity flag |
| ack_n | output | 1 | Active-low acknowledge to the sender |
| clk_req | output | 1 | Request to the stoppable clock source |
| proto_err | output | 1 | Sticky illegal-codeword flag |

## Verification
The assertions assume that the feedback bit really is the consumer's one-cycle-late copy of the validity flag, so it is high whenever the machine reaches HOLD. They also assume that the rails move only between neutral and a single raised rail, with the one deliberate illegal case excepted. The bench models the consumer as a register on the validity flag, and it derives grant from the request gated by an enable, which keeps both assumptions true. Rails are changed only after acknowledge falls or rises, as the four-phase protocol allows. The only break from the protocol is a deliberate pair of raised rails, applied while the machine is idle, that exercises the error flag.

// File: rtl/dr2s_pkg.sv
package dr2s_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_HOLD = 2'd2
    } dr2s_state_e;

    localparam int RAIL_W = 2;
    localparam int RAIL_T_BIT = 1;
    localparam int RAIL_F_BIT = 0;
endpackage

// File: rtl/dr2s_rail_sync.sv
module dr2s_rail_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[LAST];
endmodule

// File: rtl/dr2s_rail_decode.sv
module dr2s_rail_decode
    import dr2s_pkg::*;
(
    input  logic [RAIL_W-1:0] rails,
    output logic              w_valid,
    output logic              w_bit,
    output logic              w_empty,
    output logic              w_bad
);
    always_comb begin
        w_valid = rails[RAIL_T_BIT] ^ rails[RAIL_F_BIT];
        w_bit   = rails[RAIL_T_BIT] & ~rails[RAIL_F_BIT];
        w_empty = ~(rails[RAIL_T_BIT] | rails[RAIL_F_BIT]);
        w_bad   = rails[RAIL_T_BIT] & rails[RAIL_F_BIT];
    end
endmodule

// File: rtl/dr2s_fsm.sv
module dr2s_fsm
    import dr2s_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic w_valid,
    input  logic w_bit,
    input  logic w_empty,
    input  logic w_bad,
    input  logic fb,
    input  logic grant,
    output logic data_o,
    output logic valid_o,
    output logic ack_n_o,
    output logic req_o,
    output logic err_o
);
    dr2s_state_e st, nxt;
    logic        load;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Transitions
    always_comb begin
        nxt  = st;
        load = 1'b0;
        unique case (st)
            ST_IDLE: if (w_valid && !fb) begin
                nxt  = ST_LOAD;
                load = 1'b1;
            end
            ST_LOAD: if (grant && fb) nxt = ST_HOLD;
            ST_HOLD: if (w_empty)     nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Registered outputs, derived from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= 1'b0;
            valid_o <= 1'b0;
            ack_n_o <= 1'b1;
            req_o   <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= (nxt != ST_IDLE);
            ack_n_o <= (nxt == ST_IDLE);
            req_o   <= (nxt == ST_LOAD);
            if (load) data_o <= w_bit;
            if (w_bad) err_o <= 1'b1;
        end
    end
endmodule

// File: rtl/dr2s_ctrl.sv
module dr2s_ctrl
    import dr2s_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_t,
    input  logic rail_f,
    input  logic sv_fb,
    input  logic grant,
    output logic sync_data,
    output logic sync_valid,
    output logic ack_n,
    output logic clk_req,
    output logic proto_err
);
    logic [RAIL_W-1:0] rails_raw, rails_s;
    logic w_valid, w_bit, w_empty, w_bad;

    assign rails_raw = {rail_t, rail_f};

    dr2s_rail_sync #(.STAGES(SYNC_STAGES), .WIDTH(RAIL_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rails_raw),
        .sync_out (rails_s)
    );

    dr2s_rail_decode u_dec (
        .rails   (rails_s),
        .w_valid (w_valid),
        .w_bit   (w_bit),
        .w_empty (w_empty),
        .w_bad   (w_bad)
    );

    dr2s_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .w_valid (w_valid),
        .w_bit   (w_bit),
        .w_empty (w_empty),
        .w_bad   (w_bad),
        .fb      (sv_fb),
        .grant   (grant),
        .data_o  (sync_data),
        .valid_o (sync_valid),
        .ack_n_o (ack_n),
        .req_o   (clk_req),
        .err_o   (proto_err)
    );
endmodule

// File: rtl/dr2s_ctrl_chk.sv
module dr2s_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sv_fb,
    input logic grant,
    input logic sync_data,
    input logic sync_valid,
    input logic ack_n,
    input logic clk_req,
    input logic proto_err
);
    AST_ACK_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n == !sync_valid); // R5
    AST_REQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        clk_req |-> sync_valid); // R6
    AST_REQ_DROP_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(clk_req) && sync_valid) |-> $past(grant)); // R6
    AST_FALL_AFTER_FB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_valid) |-> $past(sv_fb)); // R7
    AST_RISE_FB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_valid) |-> !$past(sv_fb)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R9
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sync_valid |=> (!sync_valid || $stable(sync_data))); // R10
endmodule

bind dr2s_ctrl dr2s_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sv_fb      (sv_fb),
    .grant      (grant),
    .sync_data  (sync_data),
    .sync_valid (sync_valid),
    .ack_n      (ack_n),
    .clk_req    (clk_req),
    .proto_err  (proto_err)
);

// File: tb/dr2s_ctrl_tb.sv
`timescale 1ns/1ps
module dr2s_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rail_t = 1'b0, rail_f = 1'b0;
    logic grant_en = 1'b0, fb_stick = 1'b0;
    logic fb_reg;
    logic sv_fb, grant;
    logic sync_data, sync_valid, ack_n, clk_req, proto_err;
    int   checks = 0, fails = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    // Consumer model: registered copy of the validity flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fb_reg <= 1'b0;
        else        fb_reg <= sync_valid;
    end
    assign sv_fb = fb_reg | fb_stick;
    assign grant = clk_req & grant_en;

    dr2s_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .rail_t(rail_t), .rail_f(rail_f),
        .sv_fb(sv_fb), .grant(grant), .sync_data(sync_data),
        .sync_valid(sync_valid), .ack_n(ack_n), .clk_req(clk_req),
        .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // {true, false, hold[3:0], expected data}
    localparam int NV = 6;
    localparam logic [6:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'd1, 1'b1},
        {1'b0, 1'b1, 4'd2, 1'b0},
        {1'b0, 1'b1, 4'd1, 1'b0},
        {1'b1, 1'b0, 4'd5, 1'b1},
        {1'b1, 1'b0, 4'd3, 1'b1},
        {1'b0, 1'b1, 4'd4, 1'b0}
    };

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        edges(2);
        // R1 reset state
        chk(sync_data == 0, "R1 data", sync_data, 0);
        chk(sync_valid == 0, "R1 valid", sync_valid, 0);
        chk(ack_n == 1, "R1 ack_n", ack_n, 1);
        chk(clk_req == 0 && proto_err == 0, "R1 req/err", {clk_req, proto_err}, 0);
        rst_n = 1'b1;
        edges(2);

        for (int i = 0; i < NV; i++) begin
            rail_t = VEC[i][6]; rail_f = VEC[i][5]; grant_en = 1'b0;
            edges(2);
            chk(sync_valid == 0, "R2 latency (not yet)", sync_valid, 0);
            edges(1);
            if (VEC[i][6]) chk(sync_valid == 1 && sync_data == 1, "R2 true word", {sync_valid, sync_data}, 3);
            else           chk(sync_valid == 1 && sync_data == 0, "R3 false word", {sync_valid, sync_data}, 2);
            chk(ack_n == 0, "R5 ack low", ack_n, 0);
            chk(clk_req == 1, "R6 req raised", clk_req, 1);
            edges(int'(VEC[i][4:1]));
            chk(clk_req == 1 && sync_valid == 1, "R6 waits for grant", {clk_req, sync_valid}, 3);
            chk(sync_data == VEC[i][0], "R10 data held", sync_data, VEC[i][0]);
            rail_t = 1'b0; rail_f = 1'b0; grant_en = 1'b1;
            edges(1);
            chk(clk_req == 0 && sync_valid == 1, "R6 req drops", {clk_req, sync_valid}, 1);
            edges(2);
            chk(sync_valid == 0 && ack_n == 1, "R4 empty retires", {sync_valid, ack_n}, 1);
            chk(sync_data == VEC[i][0], "R4 data kept", sync_data, VEC[i][0]);
            edges(2);
        end

        // R7: rails empty but no grant: flag stays high
        grant_en = 1'b0;
        rail_f = 1'b1;
        edges(3);
        rail_f = 1'b0;
        edges(5);
        chk(sync_valid == 1, "R7 no fall without grant", sync_valid, 1);
        grant_en = 1'b1;
        edges(1);
        chk(sync_valid == 1, "R7 hold one cycle", sync_valid, 1);
        edges(1);
        chk(sync_valid == 0 && ack_n == 1, "R7 falls", {sync_valid, ack_n}, 1);
        edges(2);

        // R8: feedback held high blocks a new word
        fb_stick = 1'b1;
        rail_t = 1'b1;
        edges(5);
        chk(sync_valid == 0, "R8 blocked by feedback", sync_valid, 0);
        fb_stick = 1'b0;
        edges(1);
        chk(sync_valid == 1 && sync_data == 1, "R8 accepted", {sync_valid, sync_data}, 3);
        rail_t = 1'b0;
        edges(4);
        chk(sync_valid == 0, "R8 retired", sync_valid, 0);
        edges(2);

        // R9: illegal codeword
        rail_t = 1'b1; rail_f = 1'b1;
        edges(3);
        chk(proto_err == 1, "R9 error set", proto_err, 1);
        chk(sync_valid == 0 && sync_data == 1, "R9 no effect", {sync_valid, sync_data}, 1);
        rail_t = 1'b0; rail_f = 1'b0;
        edges(4);
        chk(proto_err == 1, "R9 sticky", proto_err, 1);
        rst_n = 1'b0;
        edges(1);
        chk(proto_err == 0 && sync_data == 0, "R9 reset clears", {proto_err, sync_data}, 0);
        rst_n = 1'b1;
        edges(2);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule